// File: doc/BRIEF.md
# Radix-4 Signed Booth Multiplier

This block multiplies two 8-bit two's-complement numbers: `a` is the multiplicand and `b` is the multiplier. The operand `b` is split into four radix-4 digits, each worth -2, -1, 0, +1 or +2. Each digit selects a partial product from the set {0, +A, +2A, -A, -2A}, and all four partial products are formed at the same time. The negated operand -A is built once, by a dedicated two's-complement unit, and every slice shares it. The lowest digit is read from `b[1:0]` alone, with an implicit zero below bit 0, so its slice can only produce 0, +A, -A or -2A. A carry-save reduction then adds the four weighted rows, and one carry-propagate add finishes the sum.

The arithmetic is purely combinational. It sits behind a single output register with a valid/ready handshake. A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high, and its result appears on `prod`/`ovf` with `out_valid` high from the next cycle on. The rules for back-pressure are as follows. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result stays frozen and no new beat is taken. The block does not buffer beyond that one register.

The product is 15 bits wide. Exactly one operand pair, -128 × -128 = +16384, does not fit in that range. For that pair `ovf` is raised and `prod` carries the low 15 bits of the true product.

Top module: `booth_mul_r4`

## Requirements
- R1: For every operand pair, `prod` equals the low 15 bits of the signed product `a`×`b` of the accepted beat.
- R2: `ovf` is 1 only when both operands of the accepted beat are 8'h80 (-128). In that case `prod` is 15'h4000. For every other pair `ovf` is 0.
- R3: The shared negation unit gives the 9-bit two's complement of `a`. For `a` = 8'h80 this is +128 (9'h080), so products with `a` = -128 are exact (for example -128×1 gives 15'h7F80 and -128×-1 gives 15'h0080).
- R4: Each upper slice reads the bit triple (b[2i+1], b[2i], b[2i-1]) for i = 1..3. It asserts at most one of its four selects (+A, +2A, -2A, -A). The triples 000 and 111 select nothing (zero row). The triples 001 and 010 select +A, 011 selects +2A, 100 selects -2A, and 101 and 110 select -A.
- R5: The lowest slice uses only b[1:0] with a zero below it. The pair 00 gives 0, 01 gives +A, 10 gives -2A and 11 gives -A. It never selects +2A.
- R6: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. A beat accepted at one edge shows `out_valid` high after that edge, and every accepted beat produces exactly one output transfer, in order.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `prod` and `ovf` keep their values into the next cycle.
- R8: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Block can take a beat this cycle |
| a | input | 8 | Multiplicand, two's complement |
| b | input | 8 | Multiplier, two's complement |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| prod | output | 15 | Low 15 bits of the signed product |
| ovf | output | 1 | Result does not fit in 15 signed bits (-128 × -128 only) |

## Verification
On every cycle the assertions check the following:
- the shared negation against a reference negate, including the -128 corner;
- that each slice's selects are at most one-hot;
- that the registered product and overflow flag match a reference multiply of the accepted operands;
- the ready rule;
- that the result stays frozen under back-pressure.

Only the bench scenarios can show the rest. It runs every one of the 65,536 operand pairs under random back-pressure, with results paired to beats in order. It checks that no beat is lost or duplicated. It also checks directed pairs with hand-derived products, which pin down the -128 cases, the lowest-slice digit mapping and the overflow flag.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // one select line per nonzero candidate; all low means a zero row
  typedef struct packed {
    logic pos1;
    logic pos2;
    logic neg2;
    logic neg1;
  } bsel_t;

  localparam int unsigned SEL_W = $bits(bsel_t);
endpackage

// File: rtl/booth_neg.sv
module booth_neg #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  output logic [W:0]   nega
);
  // bit k of -a flips a[k] when any lower bit of a is set
  logic [W-1:0] any_below;

  assign any_below[0] = 1'b0;

  generate
    for (genvar k = 1; k < W; k++) begin : g_below
      assign any_below[k] = |a[k-1:0];
    end
    for (genvar k = 0; k < W; k++) begin : g_bit
      assign nega[k] = a[k] ^ any_below[k];
    end
  endgenerate

  // sign-extension bit equals a[W-1], so the top bit reduces to this
  assign nega[W] = ~a[W-1] & any_below[W-1];
endmodule

// File: rtl/booth_slice.sv
module booth_slice
  import booth_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter bit          REDUCED = 1'b0,
  localparam int unsigned GW     = REDUCED ? 2 : 3,
  localparam int unsigned PPW    = W + 2
) (
  input  logic [W-1:0]   a,
  input  logic [W:0]     nega,
  input  logic [GW-1:0]  grp,
  output bsel_t          sel,
  output logic [PPW-1:0] pp
);
  logic [PPW-1:0] c_pos1, c_pos2, c_neg1, c_neg2;

  generate
    if (REDUCED) begin : g_low
      // grp = {b1, b0}; the bit below b0 is a constant zero
      assign sel.pos1 = grp[0] & ~grp[1];
      assign sel.pos2 = 1'b0;
      assign sel.neg2 = ~grp[0] & grp[1];
      assign sel.neg1 = grp[0] & grp[1];
    end else begin : g_full
      // grp = {b[2i+1], b[2i], b[2i-1]}
      logic lo_diff;
      assign lo_diff  = grp[0] ^ grp[1];
      assign sel.pos1 = lo_diff & ~grp[2];
      assign sel.pos2 = grp[0] & grp[1] & ~grp[2];
      assign sel.neg2 = ~grp[0] & ~grp[1] & grp[2];
      assign sel.neg1 = lo_diff & grp[2];
    end
  endgenerate

  // candidates widened to the row width by sign extension
  assign c_pos1 = {{2{a[W-1]}}, a};
  assign c_pos2 = {a[W-1], a, 1'b0};
  assign c_neg1 = {nega[W], nega};
  assign c_neg2 = {nega, 1'b0};

  assign pp = ({PPW{sel.pos1}} & c_pos1) |
              ({PPW{sel.pos2}} & c_pos2) |
              ({PPW{sel.neg2}} & c_neg2) |
              ({PPW{sel.neg1}} & c_neg1);
endmodule

// File: rtl/booth_sum.sv
module booth_sum #(
  parameter int unsigned W   = 8,
  localparam int unsigned NG  = W / 2,
  localparam int unsigned PPW = W + 2,
  localparam int unsigned SW  = 2 * W
) (
  input  logic [NG*PPW-1:0] pp_flat,
  output logic [SW-1:0]     sum
);
  logic [SW-1:0] row [NG];
  logic [SW-1:0] ss  [NG];
  logic [SW-1:0] cc  [NG];

  generate
    for (genvar j = 0; j < NG; j++) begin : g_row
      logic [PPW-1:0] ppj;
      logic [SW-1:0]  ext;
      assign ppj    = pp_flat[j*PPW +: PPW];
      assign ext    = {{(SW-PPW){ppj[PPW-1]}}, ppj};
      assign row[j] = ext << (2 * j);
    end

    // carry-save chain: rows 0 and 1 seed it, each later row adds a 3:2 stage
    assign ss[1] = row[0];
    assign cc[1] = row[1];
    assign ss[0] = '0;
    assign cc[0] = '0;
    for (genvar j = 2; j < NG; j++) begin : g_csa
      assign ss[j] = ss[j-1] ^ cc[j-1] ^ row[j];
      assign cc[j] = ((ss[j-1] & cc[j-1]) |
                      (ss[j-1] & row[j])  |
                      (cc[j-1] & row[j])) << 1;
    end
  endgenerate

  assign sum = ss[NG-1] + cc[NG-1];
endmodule

// File: rtl/booth_mul_r4.sv
module booth_mul_r4
  import booth_pkg::*;
#(
  parameter int unsigned W = 8,
  localparam int unsigned NG  = W / 2,
  localparam int unsigned PPW = W + 2,
  localparam int unsigned SW  = 2 * W,
  localparam int unsigned PW  = 2 * W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] prod,
  output logic          ovf
);
  logic [W:0]            nega;
  logic [NG*PPW-1:0]     pp_flat;
  logic [NG*SEL_W-1:0]   sel_flat;
  logic [SW-1:0]         sum;
  logic                  take;

  booth_neg #(.W(W)) u_neg (
    .a    (a),
    .nega (nega)
  );

  generate
    for (genvar g = 0; g < NG; g++) begin : g_slice
      bsel_t sel_g;
      if (g == 0) begin : g_lo
        booth_slice #(.W(W), .REDUCED(1'b1)) u_slice (
          .a    (a),
          .nega (nega),
          .grp  (b[1:0]),
          .sel  (sel_g),
          .pp   (pp_flat[0 +: PPW])
        );
      end else begin : g_hi
        booth_slice #(.W(W), .REDUCED(1'b0)) u_slice (
          .a    (a),
          .nega (nega),
          .grp  (b[2*g+1 : 2*g-1]),
          .sel  (sel_g),
          .pp   (pp_flat[g*PPW +: PPW])
        );
      end
      assign sel_flat[g*SEL_W +: SEL_W] = sel_g;
    end
  endgenerate

  booth_sum #(.W(W)) u_sum (
    .pp_flat (pp_flat),
    .sum     (sum)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      prod      <= '0;
      ovf       <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      prod      <= sum[PW-1:0];
      ovf       <= sum[SW-1] ^ sum[SW-2];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/booth_mul_r4_chk.sv
module booth_mul_r4_chk #(
  parameter int unsigned W = 8,
  localparam int unsigned NG = W / 2,
  localparam int unsigned PW = 2 * W - 1,
  localparam int unsigned SL = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic           out_valid,
  input logic           out_ready,
  input logic [PW-1:0]  prod,
  input logic           ovf,
  input logic [W:0]     nega,
  input logic [NG*SL-1:0] sel_flat
);
  logic signed [2*W-1:0] ref_full;
  logic [PW-1:0]         ref_prod;
  logic                  ref_ovf;
  logic [W:0]            ref_neg;
  logic [W-1:0]          min_val;

  assign min_val  = {1'b1, {(W-1){1'b0}}};
  assign ref_full = (2*W)'($signed(a)) * (2*W)'($signed(b));
  assign ref_prod = ref_full[PW-1:0];
  assign ref_ovf  = (a == min_val) && (b == min_val);
  assign ref_neg  = (W+1)'(0) - {a[W-1], a};

  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (prod == $past(ref_prod)));

  a_r2_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (ovf == $past(ref_ovf)));

  a_r3_negate: assert property (@(posedge clk) disable iff (!rst_n)
    nega == ref_neg);

  generate
    for (genvar g = 0; g < NG; g++) begin : g_sel
      a_r4_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_flat[g*SL +: SL]));
    end
  endgenerate

  a_r6_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(prod) && $stable(ovf)));
endmodule

bind booth_mul_r4 booth_mul_r4_chk #(.W(W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .a         (a),
  .b         (b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .prod      (prod),
  .ovf       (ovf),
  .nega      (nega),
  .sel_flat  (sel_flat)
);

// File: tb/test_booth_mul_r4.sv
`timescale 1ns/1ps
module test_booth_mul_r4;
  localparam int ND    = 13;
  localparam int TOTAL = ND + 65536;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  a, b;
  logic        out_valid;
  logic        out_ready;
  logic [14:0] prod;
  logic        ovf;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [14:0] qp[$];
  logic        qo[$];
  string       qt[$];

  always #2 clk = ~clk;

  booth_mul_r4 i_booth_mul_r4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .out_valid(out_valid), .out_ready(out_ready),
    .prod(prod), .ovf(ovf)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // {a, b, expected prod, expected ovf}, worked out by hand
  function automatic logic [31:0] directed(input int k);
    case (k)
      0:  return {8'h80, 8'h80, 15'h4000, 1'b1};
      1:  return {8'h80, 8'h01, 15'h7F80, 1'b0};
      2:  return {8'h80, 8'hFF, 15'h0080, 1'b0};
      3:  return {8'h80, 8'h7F, 15'h4080, 1'b0};
      4:  return {8'h7F, 8'h7F, 15'h3F01, 1'b0};
      5:  return {8'h05, 8'h01, 15'h0005, 1'b0};
      6:  return {8'h05, 8'h02, 15'h000A, 1'b0};
      7:  return {8'h05, 8'h03, 15'h000F, 1'b0};
      8:  return {8'h07, 8'h18, 15'h00A8, 1'b0};
      9:  return {8'h07, 8'h0C, 15'h0054, 1'b0};
      10: return {8'hFF, 8'h80, 15'h0080, 1'b0};
      11: return {8'h00, 8'h80, 15'h0000, 1'b0};
      default: return {8'h80, 8'h00, 15'h0000, 1'b0};
    endcase
  endfunction

  function automatic string dtag(input int k);
    case (k)
      0, 10:       return "R2";
      1, 2, 3, 12: return "R3";
      5, 6, 7:     return "R5";
      8, 9:        return "R4";
      default:     return "R1";
    endcase
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lf;
    logic [14:0] held_p;
    logic        held_o;
    bit          stall, took;
    int          item, popped;
    lf = 16'hACE1;
    stall = 1'b0; took = 1'b0;
    item = 0; popped = 0;
    held_p = '0; held_o = 1'b0;
    in_valid = 1'b0; a = '0; b = '0; out_ready = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R8", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;

    while (popped < TOTAL) begin
      @(negedge clk);
      if (stall) begin
        check(out_valid == 1'b1, "R7", "valid held", int'(out_valid), 1);
        check(prod == held_p, "R7", "prod held", int'(prod), int'(held_p));
        check(ovf == held_o, "R7", "ovf held", int'(ovf), int'(held_o));
      end
      if (took)
        check(out_valid == 1'b1, "R6", "valid after accept", int'(out_valid), 1);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_ready = |lf[1:0];
      if (item < ND) begin
        logic [31:0] d;
        d = directed(item);
        in_valid = 1'b1; a = d[31:24]; b = d[23:16];
      end else if (item < TOTAL) begin
        int e;
        e = item - ND;
        in_valid = 1'b1; a = e[15:8]; b = e[7:0];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      check(in_ready == (!out_valid || out_ready), "R6", "ready rule",
            int'(in_ready), int'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (qp.size() == 0) begin
          check(1'b0, "R6", "result with no beat", 1, 0);
        end else begin
          logic [14:0] ep;
          logic        eo;
          string       et;
          ep = qp.pop_front(); eo = qo.pop_front(); et = qt.pop_front();
          check(prod == ep, et, "prod", int'(prod), int'(ep));
          check(ovf == eo, "R2", "ovf", int'(ovf), int'(eo));
        end
        popped++;
      end
      stall  = out_valid && !out_ready;
      held_p = prod;
      held_o = ovf;
      took   = in_valid && in_ready;
      if (took) begin
        if (item < ND) begin
          logic [31:0] d;
          d = directed(item);
          qp.push_back(d[15:1]); qo.push_back(d[0]); qt.push_back(dtag(item));
        end else begin
          int full;
          logic eov;
          full = int'($signed(a)) * int'($signed(b));
          eov  = (a == 8'h80) && (b == 8'h80);
          qp.push_back(full[14:0]); qo.push_back(eov);
          qt.push_back(eov ? "R2" : "R1");
        end
        item++;
      end
    end
    check(qp.size() == 0, "R6", "beats left over", qp.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule